// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a synchronous host port to an external asynchronous static RAM of 32,768 bytes. The host presents a one-cycle request with a write flag, a 15-bit address and a write byte. The controller runs one complete memory cycle and answers with a single-cycle completion pulse. After a read it also returns the fetched byte. On the memory side it drives a 15-bit address, three active-low strobes (select, output enable, write enable) and a split bidirectional data bus (drive value, drive enable, sampled input).

The controller works from a small phase machine.
- A read keeps select and output enable low, with write enable high, for a parameterised number of wait cycles. That count is derived by default from the memory access time and the clock period.
- A write runs three phases: one address-setup cycle, a parameterised write-enable pulse, and one data-hold cycle.
- A write that follows a read first spends one deselected turnaround cycle, so the memory has released the bus before the controller drives it.

Between transfers the memory is deselected, which lets it fall into its own low-power state.

Top module: `async_sram_bridge`

## Requirements
- R1: While reset is asserted and on the first cycle after it, select, output enable and write enable are all high (1), the data driver is off, and the completion pulse is low.
- R2: Whenever no transfer is in progress (idle or turnaround), the select strobe is high.
- R3: A read accepted at clock edge E shows select=0, output enable=0, write enable=1 for exactly RD_WAIT cycles following E. The byte on the data input during the last of those cycles becomes the host read data, and the completion pulse is high in the cycle after them (RD_WAIT+1 cycles after E).
- R4: A write accepted at edge E, with no turnaround, runs three phases in order.
  - One setup cycle: select=0, write enable=1, driver off.
  - WR_PULSE cycles: write enable=0, driver on, write byte on the bus.
  - One hold cycle: write enable=1, driver still on.
  Output enable stays high throughout. The completion pulse follows, WR_PULSE+3 cycles after E.
- R5: The data driver is on only while write enable is low or in the single cycle after it rises. It is never on while output enable is low.
- R6: A write whose previous transfer was a read first spends one cycle with select high and the driver off, so its completion comes WR_PULSE+4 cycles after acceptance.
- R7: The memory address and the driven write byte are those present at acceptance. They stay stable for the whole transfer even if the host inputs change.
- R8: Each transfer produces exactly one completion pulse, one clock cycle wide.
- R9: A request raised while a transfer is busy is ignored. It produces no completion and no memory write.
- R10: The host read data holds its value until the next read completes. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Transfer request, sampled when idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Word address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Last read byte |
| host_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 15 | Memory address bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The two functions that can meet in one cycle are the end of a read, where the memory is still driving, and the start of a following write, where the controller would begin to drive. The bench provokes this by issuing a write immediately after a read completes. It judges the result cycle by cycle at the pins: one deselected gap, no driver while output enable is low, and the completion arriving one cycle later than for a plain write. A second collision, a fresh request raised during a busy read, is judged by the absence of any extra completion and by reading the target address back unchanged.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_TURN  = 3'd1,
    PH_READ  = 3'd2,
    PH_WSET  = 3'd3,
    PH_WPUL  = 3'd4,
    PH_WHOLD = 3'd5
  } phase_t;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } pins_t;

  // Number of whole clock cycles needed to cover an access time.
  function automatic int unsigned wait_cycles(input int unsigned acc_ps,
                                              input int unsigned clk_ps);
    int unsigned c;
    c = (acc_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  // Strobe pattern for each phase of the sequencer.
  function automatic pins_t phase_pins(input phase_t ph);
    pins_t p;
    p = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    case (ph)
      PH_READ:  p = '{cs_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
      PH_WSET:  p = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
      PH_WPUL:  p = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
      PH_WHOLD: p = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
      default:  p = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_bridge_pkg::*;
#(
  parameter int unsigned RD_WAIT  = 2,
  parameter int unsigned WR_PULSE = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   wr,
  output phase_t phase,
  output logic   accept,
  output logic   rd_capture,
  output logic   busy,
  output logic   done
);
  localparam int unsigned LONGEST = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE;
  localparam int          CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_PULSE - 1);

  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_rd_q;
  logic             done_q;
  logic             cnt_zero;
  logic             wr_finish;

  assign cnt_zero   = (cnt_q == '0);
  assign accept     = (ph_q == PH_IDLE) && req;
  assign rd_capture = (ph_q == PH_READ) && cnt_zero;
  assign wr_finish  = (ph_q == PH_WHOLD);
  assign busy       = (ph_q != PH_IDLE);
  assign phase      = ph_q;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      last_rd_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= rd_capture || wr_finish;
      case (ph_q)
        PH_IDLE: if (req) begin
          if (wr) begin
            ph_q      <= last_rd_q ? PH_TURN : PH_WSET;
            last_rd_q <= 1'b0;
          end else begin
            ph_q  <= PH_READ;
            cnt_q <= RD_LOAD;
          end
        end
        PH_TURN: ph_q <= PH_WSET;
        PH_WSET: begin
          ph_q  <= PH_WPUL;
          cnt_q <= WR_LOAD;
        end
        PH_WPUL: begin
          if (cnt_zero) ph_q <= PH_WHOLD;
          else          cnt_q <= cnt_q - 1'b1;
        end
        PH_WHOLD: ph_q <= PH_IDLE;
        PH_READ: begin
          if (cnt_zero) begin
            ph_q      <= PH_IDLE;
            last_rd_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R8: the completion pulse never lasts two cycles
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: a request during a busy transfer is not accepted
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> !$past(accept));

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_bridge_pkg::*;
(
  input  phase_t phase,
  output logic   cs_n,
  output logic   oe_n,
  output logic   we_n,
  output logic   drive
);
  pins_t p;
  always_comb p = phase_pins(phase);
  assign cs_n  = p.cs_n;
  assign oe_n  = p.oe_n;
  assign we_n  = p.we_n;
  assign drive = p.drive;
endmodule

// File: rtl/sram_hold_regs.sv
module sram_hold_regs #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_in;
        wdata_q <= wdata_in;
      end
      if (capture) rdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/async_sram_bridge.sv
module async_sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned ACCESS_PS = 12000,
  parameter int unsigned RD_WAIT   = wait_cycles(ACCESS_PS, CLK_PS),
  parameter int unsigned WR_PULSE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  phase_t phase;
  logic   accept;
  logic   rd_capture;
  logic   busy;

  sram_phase_seq #(.RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(host_req), .wr(host_wr),
    .phase(phase), .accept(accept), .rd_capture(rd_capture),
    .busy(busy), .done(host_done)
  );

  sram_pin_decode u_pins (
    .phase(phase), .cs_n(mem_cs_n), .oe_n(mem_oe_n),
    .we_n(mem_we_n), .drive(mem_dq_oe)
  );

  sram_hold_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .addr_in(host_addr), .wdata_in(host_wdata),
    .capture(rd_capture), .dq_in(mem_dq_in),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .rdata_q(host_rdata)
  );

  // R2: deselected whenever the sequencer is not busy
  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mem_cs_n);

  // R3: read data is taken only while the memory is driving
  p_capture_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!mem_cs_n && !mem_oe_n && mem_we_n));

  // R4: output enable stays high while writing, with data driven
  p_write_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_cs_n));

  // R5: driver only during the write pulse or one hold cycle after it
  p_drive_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

  // R5: never drive against an enabled memory output
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R6: no driving in the cycle after the memory output was enabled
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_oe_n) |-> !mem_dq_oe);

  // R7: address and write byte stable while the memory stays selected
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R10: host read data changes only on a capture
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_capture) |-> $stable(host_rdata));

endmodule

// File: tb/async_sram_bridge_tb_top.sv
module async_sram_bridge_tb_top;
  localparam int RDW = 2;   // ceil(12 ns / 10 ns)
  localparam int WP  = 2;
  localparam int ACC = 2;   // memory model access, in cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [14:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_done;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0, failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  async_sram_bridge #(.CLK_PS(10000), .ACCESS_PS(12000), .WR_PULSE(WP)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Behavioural memory: 1024 rows x 32 columns x 8 bits
  logic [7:0] store [int unsigned];
  int         rd_age = 0;
  int         mem_writes = 0;

  function automatic int unsigned cell_key(input logic [14:0] a);
    logic [9:0] row;
    logic [4:0] col;
    row = a[14:5];
    col = a[4:0];
    return int'(row) * 32 + int'(col);
  endfunction

  function automatic logic [7:0] fill_of(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] peek(input logic [14:0] a);
    int unsigned k;
    k = cell_key(a);
    if (store.exists(k)) return store[k];
    return fill_of(a);
  endfunction

  logic rd_en;
  assign rd_en = !mem_cs_n && !mem_oe_n && mem_we_n;

  always_comb begin
    if (rd_en && rd_age >= ACC - 1) mem_dq_in = peek(mem_addr);
    else                            mem_dq_in = 8'hEE;
  end

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n) begin
      store[cell_key(mem_addr)] = mem_dq_oe ? mem_dq_out : 8'hEE;
      mem_writes = mem_writes + 1;
    end
    rd_age <= rd_en ? rd_age + 1 : 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One transfer. Checks every cycle's pins and the completion latency.
  task automatic xfer(input bit wr, input logic [14:0] a, input logic [7:0] d,
                      input bit turn, input bit scramble, input bit poke,
                      input string tag);
    int lat, off, bad, done_at, dones;
    bit cs_e, oe_e, we_e, dr_e;
    off = turn ? 1 : 0;
    lat = wr ? (WP + 3 + off) : (RDW + 1);
    bad = 0; done_at = -1; dones = 0;
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    for (int n = 1; n <= lat + 4; n++) begin
      @(negedge clk);
      if (n == 1) begin
        if (poke) begin
          host_wr = 1'b1; host_addr = a ^ 15'h0100; host_wdata = 8'hFF;
        end else host_req = 1'b0;
        if (scramble) begin host_addr = ~a; host_wdata = ~d; end
      end
      if (n == 2) host_req = 1'b0;
      cs_e = 1; oe_e = 1; we_e = 1; dr_e = 0;
      if (!wr && n <= RDW) begin cs_e = 0; oe_e = 0; end
      if (wr && n == off + 1) cs_e = 0;
      if (wr && n >= off + 2 && n <= off + 1 + WP) begin cs_e = 0; we_e = 0; dr_e = 1; end
      if (wr && n == off + WP + 2) begin cs_e = 0; dr_e = 1; end
      if ({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe} != {cs_e, oe_e, we_e, dr_e}) bad++;
      if (!mem_cs_n && mem_addr != a) bad++;
      if (mem_dq_oe && mem_dq_out != d) bad++;
      if (mem_dq_oe && !mem_oe_n) bad++;
      if (host_done) begin dones++; if (done_at < 0) done_at = n; end
    end
    chk(bad == 0, {tag, " strobe sequence (R2 R4 R5 R7)"}, bad, 0);
    chk(done_at == lat, {tag, " completion latency (R3 R4 R6)"}, done_at, lat);
    chk(dones == 1, {tag, " single completion (R8)"}, dones, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, host_done} == 5'b11100,
        "R1 pins in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, host_done}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, host_done} == 5'b11100,
        "R1 pins after reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, host_done}, 5'b11100);
  endtask

  task automatic t_read_plain;
    xfer(1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, "R3 read");
    chk(host_rdata == fill_of(15'h0000), "R3 read data", host_rdata, fill_of(15'h0000));
  endtask

  task automatic t_write_after_read;
    xfer(1'b1, 15'h1234, 8'hA5, 1'b1, 1'b0, 1'b0, "R6 turnaround write");
    chk(peek(15'h1234) == 8'hA5, "R6 stored byte", peek(15'h1234), 8'hA5);
  endtask

  task automatic t_write_plain;
    xfer(1'b1, 15'h1235, 8'h3C, 1'b0, 1'b0, 1'b0, "R4 write");
    chk(peek(15'h1235) == 8'h3C, "R4 stored byte", peek(15'h1235), 8'h3C);
    chk(host_rdata == fill_of(15'h0000), "R10 rdata held over writes", host_rdata, fill_of(15'h0000));
  endtask

  task automatic t_column_edge;
    xfer(1'b1, 15'h001F, 8'h11, 1'b0, 1'b0, 1'b0, "R4 col31");
    xfer(1'b1, 15'h0020, 8'h22, 1'b0, 1'b0, 1'b0, "R4 row1col0");
    xfer(1'b0, 15'h001F, 8'h00, 1'b0, 1'b0, 1'b0, "R3 col31 read");
    chk(host_rdata == 8'h11, "R3 col31 data", host_rdata, 8'h11);
    xfer(1'b1, 15'h7FFF, 8'h81, 1'b1, 1'b0, 1'b0, "R6 top address write");
    xfer(1'b0, 15'h7FFF, 8'h00, 1'b0, 1'b0, 1'b0, "R3 top address read");
    chk(host_rdata == 8'h81, "R3 top address data", host_rdata, 8'h81);
  endtask

  task automatic t_scramble;
    xfer(1'b1, 15'h0040, 8'h77, 1'b1, 1'b1, 1'b0, "R7 scrambled write");
    chk(peek(15'h0040) == 8'h77, "R7 latched byte", peek(15'h0040), 8'h77);
    chk(peek(~15'h0040) == fill_of(~15'h0040), "R7 no stray write", peek(~15'h0040), fill_of(~15'h0040));
  endtask

  task automatic t_busy_poke;
    int w0;
    w0 = mem_writes;
    xfer(1'b0, 15'h1234, 8'h00, 1'b0, 1'b0, 1'b1, "R9 busy read");
    chk(mem_writes == w0, "R9 no memory write", mem_writes - w0, 0);
    chk(peek(15'h1334) == fill_of(15'h1334), "R9 target untouched", peek(15'h1334), fill_of(15'h1334));
    chk(host_rdata == 8'hA5, "R9 read unaffected", host_rdata, 8'hA5);
  endtask

  task automatic t_idle_gap;
    int hi;
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_cs_n && !mem_dq_oe && !host_done) hi++;
    end
    chk(hi == 6, "R2 idle deselect", hi, 6);
  endtask

  initial begin
    t_reset();
    t_read_plain();
    t_write_after_read();
    t_write_plain();
    t_idle_gap();
    t_column_edge();
    t_scramble();
    t_busy_poke();
    t_idle_gap();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !finished) begin
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule